// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects edge-signalled interrupt requests from eight peripheral lines and presents a single interrupt line to a processor. Each line has a request bit, an in-service bit and a mask bit. A fixed priority orders the lines: line 0 ranks highest and line 7 lowest. The interrupt output rises only when an unmasked pending request outranks every line already being serviced. This lets a more urgent source interrupt a handler that is still running.

The processor answers with two acknowledge pulses. The first pulse moves the winning line from pending to in-service. During the second pulse the block drives an 8-bit vector on the data output. The vector is an 8-aligned base with the line number in its low three bits.

Software uses a small write port to set the vector base and the mask. It also issues a non-specific end-of-interrupt command, which retires the highest-ranked handler in service. In-service bits are cleared only by that command.

Top module: `pic_ctrl`

## Requirements
- R1: After synchronous active-high reset, `int_out` is 0, `data_oe` is 0, `data_out` is 0x00, every mask bit is 1 and the vector base is 0x00. Because every line is masked, a request made before any mask write does not raise `int_out`.
- R2: A request is latched on a rising edge of its input line.
  - A line that is held high produces one request only.
  - A latched request stays pending after the line falls, until it is acknowledged.
- R3: A mask bit of 1 (written at address 1, bit n for line n) keeps that line from raising `int_out`. Its request still stays pending, and it raises `int_out` once the mask bit is cleared.
- R4: Among unmasked pending lines, the lowest-numbered line wins. Its number appears in the acknowledge vector.
- R5: `int_out` is 1 only if some unmasked pending line has a lower number than every line whose in-service bit is set. A request from a line of equal or lower rank waits.
- R6: A write to address 0 sets the vector base. Bits 2:0 of the written value are discarded, so they read as zero. The vector is base[7:3] concatenated with the 3-bit line number.
- R7: Acknowledge takes two pulses on `inta`; a pulse is a cycle in which `inta` is 1 after a cycle in which it was 0.
  - The first pulse moves the winning request into service.
  - `data_oe` is 1 and `data_out` carries the vector only while `inta` is high during the second pulse.
  - At all other times `data_oe` is 0 and `data_out` is 0x00.
- R8: `int_out` falls in the cycle after the first pulse and stays low until the second pulse has been taken. Priority is then evaluated again in the next cycle.
- R9: Writing 0x20 to address 2 clears the lowest-numbered set in-service bit, and priority is evaluated again in the next cycle. Any other value written to address 2 has no effect, and in-service bits never clear on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge sensitive |
| inta | input | 1 | Acknowledge pulses from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 vector base, 1 mask, 2 command |
| wr_data | input | 8 | Write data |
| int_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Vector during the second acknowledge pulse, else zero |
| data_oe | output | 1 | High while `data_out` carries the vector |

## Verification
A table of runs drives different combinations of mask and simultaneous requests. Each run ends in an expected vector or in no interrupt at all. Together the runs separate lowest-number-wins arbitration from masking and from vector formation.

Directed sequences cover several cases:
- a line held high, which tells edge detection apart from level detection;
- a request that stays masked and is then released;
- nested handlers, where lower- and higher-ranked requests arrive during service and the two end-of-interrupt commands must retire the handlers in rank order;
- an unaligned base write, a non-matching command value, and the bus state in each phase of the acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_WAIT2 = 1'b1
    } ack_state_e;

    localparam logic [1:0] ADDR_BASE = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;

    localparam logic [7:0] CMD_EOI_NONSPEC = 8'h20;

    typedef struct packed {
        logic       valid;
        logic [2:0] idx;
    } grant_t;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] take,
    output logic [N_LINES-1:0] irr
);
    logic [N_LINES-1:0] irq_q;
    logic [N_LINES-1:0] rise;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            irr   <= '0;
        end else begin
            irq_q <= irq_in;
            irr   <= (irr & ~take) | rise;
        end
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
    import pic_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] imr,
    input  logic [N_LINES-1:0] isr,
    output grant_t             grant
);
    logic [N_LINES-1:0] allowed;
    logic [N_LINES-1:0] eligible;

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            blocked    = blocked | isr[i];
            allowed[i] = ~blocked;
        end
    end

    assign eligible = irr & ~imr & allowed;

    always_comb begin
        grant = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                grant.valid = 1'b1;
                grant.idx   = 3'(i);
            end
        end
    end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inta,
    input  grant_t             grant,
    input  logic               eoi,
    input  logic [DW-1:0]      base,
    output logic [N_LINES-1:0] isr,
    output logic [N_LINES-1:0] take,
    output logic               in_ack,
    output logic               data_oe,
    output logic [DW-1:0]      data_out
);
    localparam int LW = $clog2(N_LINES);

    ack_state_e         state;
    logic               inta_q;
    logic               pulse;
    logic [DW-1:0]      vec_q;
    logic [N_LINES-1:0] eoi_clr;
    logic [N_LINES-1:0] set_bit;

    assign pulse  = inta & ~inta_q;
    assign in_ack = (state == ACK_WAIT2);

    always_comb begin
        set_bit = '0;
        if (pulse && state == ACK_IDLE && grant.valid)
            set_bit[grant.idx] = 1'b1;
    end
    assign take = set_bit;

    always_comb begin
        eoi_clr = '0;
        if (eoi) begin
            for (int i = N_LINES - 1; i >= 0; i--) begin
                if (isr[i]) begin
                    eoi_clr    = '0;
                    eoi_clr[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ACK_IDLE;
            inta_q <= 1'b0;
            isr    <= '0;
            vec_q  <= '0;
        end else begin
            inta_q <= inta;
            isr    <= (isr & ~eoi_clr) | set_bit;
            if (pulse) begin
                if (state == ACK_IDLE) begin
                    state <= ACK_WAIT2;
                    if (grant.valid)
                        vec_q <= {base[DW-1:LW], grant.idx[LW-1:0]};
                    else
                        vec_q <= {base[DW-1:LW], {LW{1'b1}}};
                end else begin
                    state <= ACK_IDLE;
                end
            end
        end
    end

    assign data_oe  = in_ack & inta & ~inta_q;
    assign data_out = data_oe ? vec_q : '0;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               inta,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic               int_out,
    output logic [DW-1:0]      data_out,
    output logic               data_oe
);
    localparam int LW = $clog2(N_LINES);

    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr;
    logic [N_LINES-1:0] imr_q;
    logic [N_LINES-1:0] take;
    logic [DW-1:0]      base_q;
    logic               eoi;
    logic               in_ack;
    grant_t             grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q  <= '1;
            base_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_BASE)
                base_q <= {wr_data[DW-1:LW], {LW{1'b0}}};
            if (wr_addr == ADDR_MASK)
                imr_q <= wr_data[N_LINES-1:0];
        end
    end

    assign eoi = wr_en && (wr_addr == ADDR_CMD) && (wr_data == CMD_EOI_NONSPEC);

    pic_req_latch #(.N_LINES(N_LINES)) u_req (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .take   (take),
        .irr    (irr)
    );

    pic_prio #(.N_LINES(N_LINES)) u_prio (
        .irr   (irr),
        .imr   (imr_q),
        .isr   (isr),
        .grant (grant)
    );

    pic_ack_seq #(.N_LINES(N_LINES), .DW(DW)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .inta     (inta),
        .grant    (grant),
        .eoi      (eoi),
        .base     (base_q),
        .isr      (isr),
        .take     (take),
        .in_ack   (in_ack),
        .data_oe  (data_oe),
        .data_out (data_out)
    );

    assign int_out = grant.valid & ~in_ack;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
    parameter int N_LINES = 8,
    parameter int DW      = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               inta,
    input logic               int_out,
    input logic               data_oe,
    input logic [DW-1:0]      data_out,
    input logic [DW-1:0]      base,
    input logic [N_LINES-1:0] irr,
    input logic [N_LINES-1:0] imr,
    input logic [N_LINES-1:0] isr,
    input logic               eoi
);
    logic inta_d;
    always_ff @(posedge clk) begin
        if (rst) inta_d <= 1'b0;
        else     inta_d <= inta;
    end

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_out == '0); // R7

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> data_out[DW-1:3] == base[DW-1:3]); // R6

    AST_INT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (inta && !inta_d && int_out) |=> !int_out); // R8

    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (irr & ~imr) != '0); // R3

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (inta && !inta_d && int_out && !eoi) |=> $countones(isr) == $past($countones(isr)) + 1); // R7

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr != '0 && !(inta && !inta_d)) |=> $countones(isr) + 1 == $past($countones(isr))); // R9

    AST_SERVICE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !eoi |=> (isr & $past(isr)) == $past(isr)); // R9
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_LINES(N_LINES), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .inta     (inta),
    .int_out  (int_out),
    .data_oe  (data_oe),
    .data_out (data_out),
    .base     (base_q),
    .irr      (irr),
    .imr      (imr_q),
    .isr      (isr),
    .eoi      (eoi)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       inta;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       int_out;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pic_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .inta(inta),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .int_out(int_out), .data_out(data_out), .data_oe(data_oe)
    );

    // Row layout: {mask, request lines, expected vector (0x00 means no interrupt)}.
    localparam int NV = 7;
    localparam logic [23:0] VEC_TBL [NV] = '{
        {8'h00, 8'h02, 8'h31},
        {8'h00, 8'h84, 8'h32},
        {8'h01, 8'h03, 8'h31},
        {8'hF0, 8'hF8, 8'h33},
        {8'h00, 8'h80, 8'h37},
        {8'h7F, 8'hFF, 8'h37},
        {8'hFF, 8'h10, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_in = '0; inta = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_lines(input logic [7:0] l);
        irq_in = l;
        tick();
        irq_in = '0;
        tick();
    endtask

    task automatic acknowledge(output logic [7:0] vec, output logic oe2, output logic oe1, output logic int_mid);
        inta = 1'b1;
        #1 oe1 = data_oe;
        tick();
        inta = 1'b0;
        #1 int_mid = int_out;
        tick();
        inta = 1'b1;
        #1;
        vec = data_out;
        oe2 = data_oe;
        tick();
        inta = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe2, oe1, im;

        // R1 reset state
        do_reset();
        check("R1 int_out", int_out, 0);
        check("R1 data_oe", data_oe, 0);
        check("R1 data_out", data_out, 0);
        pulse_lines(8'h01);
        check("R1 mask all ones", int_out, 0);
        wr(2'd1, 8'h00);
        tick();
        check("R1/R3 released after unmask", int_out, 1);
        acknowledge(v, oe2, oe1, im);
        check("R1 base zero vector", v, 8'h00);
        check("R7 oe during second pulse", oe2, 1);

        // Table walk: R4 R3 R6
        for (int k = 0; k < NV; k++) begin
            do_reset();
            wr(2'd0, 8'h30);
            wr(2'd1, VEC_TBL[k][23:16]);
            pulse_lines(VEC_TBL[k][15:8]);
            if (VEC_TBL[k][7:0] == 8'h00) begin
                check("R3 masked row int_out", int_out, 0);
            end else begin
                check("R4 row int_out", int_out, 1);
                acknowledge(v, oe2, oe1, im);
                check("R4 row vector", v, VEC_TBL[k][7:0]);
            end
        end

        // R2 held-high line produces one request
        do_reset();
        wr(2'd1, 8'h00);
        irq_in = 8'h10;
        tick(); tick();
        check("R2 edge latched", int_out, 1);
        acknowledge(v, oe2, oe1, im);
        wr(2'd2, 8'h20);
        tick();
        check("R2 held line no second request", int_out, 0);
        irq_in = 8'h00;
        tick();
        check("R2 fall no request", int_out, 0);
        // R2 request persists after line falls
        pulse_lines(8'h40);
        tick(); tick();
        check("R2 pending persists", int_out, 1);

        // R3 masked pending released
        do_reset();
        wr(2'd0, 8'h30);
        wr(2'd1, 8'h20);
        pulse_lines(8'h20);
        check("R3 masked blocks", int_out, 0);
        wr(2'd1, 8'h00);
        tick();
        check("R3 unmask raises", int_out, 1);
        acknowledge(v, oe2, oe1, im);
        check("R3 vector", v, 8'h35);

        // R5/R7/R8/R9 nesting
        do_reset();
        wr(2'd0, 8'h30);
        wr(2'd1, 8'h00);
        pulse_lines(8'h08);
        irq_in = 8'h02;  // line 1 arrives as the acknowledge starts
        acknowledge(v, oe2, oe1, im);
        irq_in = 8'h00;
        check("R7 no oe on first pulse", oe1, 0);
        check("R8 int low between pulses", im, 0);
        check("R7 vector line3", v, 8'h33);
        check("R7 bus zero after", data_out, 0);
        check("R5 higher rank nests", int_out, 1);
        acknowledge(v, oe2, oe1, im);
        check("R5 nested vector", v, 8'h31);
        pulse_lines(8'h20);
        check("R5 lower rank waits", int_out, 0);
        wr(2'd2, 8'h21);
        tick();
        check("R9 other command ignored", int_out, 0);
        wr(2'd2, 8'h20);
        tick();
        check("R9 first eoi retires line1 only", int_out, 0);
        wr(2'd2, 8'h20);
        tick();
        check("R9 second eoi releases line5", int_out, 1);
        acknowledge(v, oe2, oe1, im);
        check("R9 line5 vector", v, 8'h35);

        // R6 unaligned base
        do_reset();
        wr(2'd0, 8'h4F);
        wr(2'd1, 8'h00);
        pulse_lines(8'h04);
        acknowledge(v, oe2, oe1, im);
        check("R6 base low bits dropped", v, 8'h4A);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule